// File: doc/BRIEF.md
# Echo-Monitored Shared Bus Access Controller

This block decides when a station may drive a shared open-drain serial line that several stations use in a point-to-multipoint network. The line behaves as a wired-AND, and every station hears the resulting level on an echo input. Before a station may start a frame, the controller needs to see an unbroken run of ones on the echo. The length of that run depends on the station's class and on its current priority level.

While a frame is on the line, the controller checks each bit it drives against the echo of that same bit. A station that drives a zero always hears a zero, so it carries on. A station that drives a one and hears a zero has lost the line. It releases the line at once, reports a collision and waits for the next idle run. Its frame request stays pending so that the source can restart the frame. After a frame completes, the station lowers its own priority, which lengthens the idle run it needs. It returns to normal priority once it has seen that longer run while it has nothing to send.

Framing, bit stuffing and checksums belong to the frame source that feeds `tx_bit`. The controller takes a bit whenever it pulses `bit_adv`. All state changes happen only on clock edges where `bit_en` is high.

Top module: `echo_bus_arbiter`

## Requirements
- R1: After a synchronous active-high reset, the outputs are `active`=0, `bus_drive`=1, `collision`=0, `done`=0 and `bit_adv`=0. The priority is normal and the ones count is zero.
- R2: The idle run needed before a grant is 8 ones when `prio_class` is 0, and 10 ones when `prio_class` is 1, 2 or 3. It is one bit longer while the priority is lowered. The ones count saturates at 11, so a longer run still counts as enough.
- R3: While waiting, a `bit_en` edge grants the line when all three of these hold: `echo_in` is 1, that one completes the required run, and `frame_req` is 1. In the next clock, `active` is 1, `bus_drive` equals `tx_bit` as sampled at that edge, and `bit_adv` pulses for one clock. The ones count restarts from zero.
- R4: While waiting, a `bit_en` edge with `echo_in`=0 resets the ones count to zero.
- R5: While active, a `bit_en` edge with no collision and `frame_req`=1 loads `tx_bit` into `bus_drive` and pulses `bit_adv` for one clock.
- R6: While active, a `bit_en` edge with `bus_drive`=1 and `echo_in`=0 is a collision. In the next clock, `collision` pulses for one clock, `active` is 0 and `bus_drive` is 1. The priority level is unchanged and counting restarts from zero. A collision takes precedence over the end of a frame.
- R7: While active, a `bit_en` edge with no collision and `frame_req`=0 ends the frame. In the next clock, `done` pulses for one clock, `active` is 0 and `bus_drive` is 1, and the priority becomes lowered.
- R8: While the priority is lowered and `frame_req` is 0, completing the lowered-priority idle run returns the priority to normal.
- R9: On clock edges with `bit_en`=0, `active`, `bus_drive`, the priority level and the ones count keep their values, and no `bit_adv` pulse occurs.
- R10: Whenever `active` is 0, `bus_drive` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-period enable; state advances only when it is high |
| echo_in | input | 1 | Level heard back from the shared line |
| frame_req | input | 1 | Frame source has a frame ready; low while active ends the frame |
| tx_bit | input | 1 | Next serial bit from the frame source |
| prio_class | input | 2 | Station class: 0 needs the short run, any other value needs the long run |
| active | output | 1 | Line granted and a frame is in progress |
| bus_drive | output | 1 | Bit driven onto the wired-AND line; 1 means released |
| collision | output | 1 | One-clock pulse: this station lost the line |
| done | output | 1 | One-clock pulse: the frame finished without a collision |
| bit_adv | output | 1 | One-clock pulse: `tx_bit` was consumed |

## Verification
The ones count and the priority flag are never visible at the ports. A fault in either one first shows up as a grant one or more bits early or late: `active` and `bit_adv` rise at the wrong `bit_en` edge. A lost or stuck priority flag appears only on the grant that follows a completed frame, or after a revert run. For this reason the stimulus repeats the request–grant–finish cycle under both classes and both priority levels. A wrong transmit state shows at `bus_drive` or in a missing or extra `collision`/`done` pulse in the clock right after the faulty bit edge.

// File: rtl/eba_pkg.sv
package eba_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_SEND = 1'b1
  } eba_state_e;

  function automatic int unsigned eba_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eba_prio.sv
module eba_prio #(
  parameter int unsigned RUN_SHORT = 8,
  parameter int unsigned RUN_LONG  = 10,
  parameter int unsigned PENALTY   = 1,
  parameter int unsigned CW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic [1:0]    cls,
  input  logic          set_low,
  input  logic          waiting,
  input  logic          hit,
  input  logic          req,
  output logic [CW-1:0] thr,
  output logic          lowered
);
  localparam logic [CW-1:0] T_SHORT = CW'(RUN_SHORT);
  localparam logic [CW-1:0] T_LONG  = CW'(RUN_LONG);
  localparam logic [CW-1:0] T_PEN   = CW'(PENALTY);

  logic [CW-1:0] base;

  always_comb begin
    base = (cls == 2'd0) ? T_SHORT : T_LONG;
    thr  = lowered ? (base + T_PEN) : base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lowered <= 1'b0;
    end else if (bit_en) begin
      if (set_low) begin
        lowered <= 1'b1;
      end else if (waiting && hit && !req && lowered) begin
        lowered <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eba_idle_cnt.sv
module eba_idle_cnt #(
  parameter int unsigned CW      = 4,
  parameter int unsigned CNT_MAX = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          echo,
  input  logic          counting,
  input  logic          clr,
  input  logic [CW-1:0] thr,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  localparam logic [CW-1:0] LIMIT = CW'(CNT_MAX);

  logic [CW:0] cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    hit     = echo && (cnt_inc >= {1'b0, thr});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (bit_en) begin
      if (!counting || clr || !echo) begin
        cnt <= '0;
      end else if (cnt != LIMIT) begin
        cnt <= cnt_inc[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/eba_tx_fsm.sv
module eba_tx_fsm
  import eba_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic echo,
  input  logic req,
  input  logic tx,
  input  logic hit,
  output logic waiting,
  output logic grant,
  output logic set_low,
  output logic active,
  output logic drive,
  output logic collision,
  output logic done,
  output logic adv
);
  eba_state_e st;
  logic       lost;

  always_comb begin
    waiting = (st == ST_WAIT);
    lost    = (st == ST_SEND) && drive && !echo;
    grant   = bit_en && waiting && hit && req;
    set_low = bit_en && (st == ST_SEND) && !lost && !req;
    active  = (st == ST_SEND);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_WAIT;
      drive     <= 1'b1;
      collision <= 1'b0;
      done      <= 1'b0;
      adv       <= 1'b0;
    end else begin
      collision <= 1'b0;
      done      <= 1'b0;
      adv       <= 1'b0;
      if (bit_en) begin
        unique case (st)
          ST_WAIT: begin
            if (hit && req) begin
              st    <= ST_SEND;
              drive <= tx;
              adv   <= 1'b1;
            end
          end
          ST_SEND: begin
            if (lost) begin
              st        <= ST_WAIT;
              drive     <= 1'b1;
              collision <= 1'b1;
            end else if (!req) begin
              st    <= ST_WAIT;
              drive <= 1'b1;
              done  <= 1'b1;
            end else begin
              drive <= tx;
              adv   <= 1'b1;
            end
          end
          default: st <= ST_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/echo_bus_arbiter.sv
module echo_bus_arbiter #(
  parameter int unsigned RUN_SHORT = 8,
  parameter int unsigned RUN_LONG  = 10,
  parameter int unsigned PENALTY   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       echo_in,
  input  logic       frame_req,
  input  logic       tx_bit,
  input  logic [1:0] prio_class,
  output logic       active,
  output logic       bus_drive,
  output logic       collision,
  output logic       done,
  output logic       bit_adv
);
  localparam int unsigned RUN_MAX = eba_pkg::eba_max(RUN_SHORT, RUN_LONG) + PENALTY;
  localparam int unsigned CW      = $clog2(RUN_MAX + 1);

  logic [CW-1:0] thr;
  logic [CW-1:0] ones_cnt;
  logic          hit;
  logic          waiting;
  logic          grant;
  logic          set_low;
  logic          lowered;

  eba_idle_cnt #(
    .CW      (CW),
    .CNT_MAX (RUN_MAX)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .echo     (echo_in),
    .counting (waiting),
    .clr      (grant),
    .thr      (thr),
    .cnt      (ones_cnt),
    .hit      (hit)
  );

  eba_prio #(
    .RUN_SHORT (RUN_SHORT),
    .RUN_LONG  (RUN_LONG),
    .PENALTY   (PENALTY),
    .CW        (CW)
  ) u_prio (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .cls     (prio_class),
    .set_low (set_low),
    .waiting (waiting),
    .hit     (hit),
    .req     (frame_req),
    .thr     (thr),
    .lowered (lowered)
  );

  eba_tx_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .echo      (echo_in),
    .req       (frame_req),
    .tx        (tx_bit),
    .hit       (hit),
    .waiting   (waiting),
    .grant     (grant),
    .set_low   (set_low),
    .active    (active),
    .drive     (bus_drive),
    .collision (collision),
    .done      (done),
    .adv       (bit_adv)
  );
endmodule

// File: rtl/echo_bus_arbiter_chk.sv
module echo_bus_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic echo_in,
  input logic frame_req,
  input logic active,
  input logic bus_drive,
  input logic collision,
  input logic done,
  input logic bit_adv,
  input logic lowered
);
  assert_recessive_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !active |-> bus_drive);

  assert_collision_cause_R6: assert property (@(posedge clk) disable iff (rst)
    collision |-> $past(active && bus_drive && !echo_in && bit_en));

  assert_collision_excludes_done_R6: assert property (@(posedge clk) disable iff (rst)
    collision |-> !done);

  assert_done_lowers_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (lowered && !active));

  assert_hold_without_enable_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> ($stable(active) && $stable(bus_drive) && $stable(lowered) && !bit_adv));

  assert_adv_only_active_R5: assert property (@(posedge clk) disable iff (rst)
    bit_adv |-> active);

  assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(frame_req && bit_en && echo_in));
endmodule

bind echo_bus_arbiter echo_bus_arbiter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_en    (bit_en),
  .echo_in   (echo_in),
  .frame_req (frame_req),
  .active    (active),
  .bus_drive (bus_drive),
  .collision (collision),
  .done      (done),
  .bit_adv   (bit_adv),
  .lowered   (lowered)
);

// File: tb/echo_bus_arbiter_test.sv
module echo_bus_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       echo_in = 1'b1;
  logic       frame_req = 1'b0;
  logic       tx_bit = 1'b1;
  logic [1:0] prio_class = 2'd0;
  logic       active, bus_drive, collision, done, bit_adv;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    started = 1'b0;
  bit    finished = 1'b0;
  int    col_seen = 0;
  int    done_seen = 0;
  logic [7:0] lf = 8'hA5;

  // reference model state
  int m_st = 0, m_cnt = 0, m_low = 0, m_drv = 1, m_col = 0, m_dn = 0, m_adv = 0;

  echo_bus_arbiter uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .echo_in(echo_in),
    .frame_req(frame_req), .tx_bit(tx_bit), .prio_class(prio_class),
    .active(active), .bus_drive(bus_drive), .collision(collision),
    .done(done), .bit_adv(bit_adv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    int thr;
    bit hit;
    started = 1'b1;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_low = 0; m_drv = 1; m_col = 0; m_dn = 0; m_adv = 0;
    end else begin
      m_col = 0; m_dn = 0; m_adv = 0;
      if (bit_en) begin
        thr = ((prio_class == 2'd0) ? 8 : 10) + m_low;
        if (m_st == 0) begin
          if (echo_in) begin
            hit = (m_cnt + 1) >= thr;
            if (hit && frame_req) begin
              m_st = 1; m_drv = tx_bit; m_adv = 1; m_cnt = 0;
            end else begin
              if (hit && m_low == 1 && !frame_req) m_low = 0;
              m_cnt = (m_cnt + 1 > 11) ? 11 : m_cnt + 1;
            end
          end else begin
            m_cnt = 0;
          end
        end else begin
          if (m_drv == 1 && !echo_in) begin
            m_col = 1; m_st = 0; m_drv = 1;
          end else if (!frame_req) begin
            m_dn = 1; m_st = 0; m_drv = 1; m_low = 1;
          end else begin
            m_drv = tx_bit; m_adv = 1;
          end
        end
      end
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      vectors++;
      cmp("active", int'(active), m_st);
      cmp("bus_drive", int'(bus_drive), m_drv);
      cmp("collision", int'(collision), m_col);
      cmp("done", int'(done), m_dn);
      cmp("bit_adv", int'(bit_adv), m_adv);
      if (collision === 1'b1) col_seen++;
      if (done === 1'b1) done_seen++;
    end
  end

  task automatic check(input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  function automatic logic next_tx();
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    return lf[0];
  endfunction

  // one bit period: other = level driven by a competing station
  task automatic bus_bit(input logic other, input logic req, input logic tx);
    @(negedge clk);
    bit_en = 1'b1; frame_req = req; tx_bit = tx; echo_in = bus_drive & other;
    @(negedge clk);
    bit_en = 1'b0; echo_in = ~echo_in; tx_bit = ~tx_bit;
    @(negedge clk);
  endtask

  task automatic wait_grant(output int n);
    n = 0;
    while (!active && n < 40) begin
      bus_bit(1'b1, 1'b1, next_tx());
      n++;
    end
  endtask

  task automatic send_frame(input int nbits);
    for (int i = 0; i < nbits; i++) bus_bit(1'b1, 1'b1, next_tx());
    bus_bit(1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    int c0, d0;
    // R1 reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(int'(active), 0, "active after reset");
    check(int'(bus_drive), 1, "bus_drive after reset");
    check(int'(collision | done | bit_adv), 0, "pulses after reset");

    // R2/R3: class 0 normal priority needs 8 ones
    cur_req = "R3";
    prio_class = 2'd0;
    bus_bit(1'b0, 1'b1, 1'b0);
    wait_grant(n);
    check(n, 8, "R2 class0 normal run");
    cur_req = "R5";
    d0 = done_seen;
    send_frame(12);
    cur_req = "R7";
    check(done_seen - d0, 1, "done pulse after frame");
    check(int'(active), 0, "released after frame");

    // R4: a zero mid-run restarts the count, lowered needs 9
    cur_req = "R4";
    for (int i = 0; i < 5; i++) bus_bit(1'b1, 1'b1, 1'b1);
    bus_bit(1'b0, 1'b1, 1'b1);
    wait_grant(n);
    check(n, 9, "lowered run after zero");

    // R6: collision with a competitor driving zero
    cur_req = "R6";
    c0 = col_seen;
    for (int i = 0; i < 3; i++) bus_bit(1'b1, 1'b1, 1'b1);
    bus_bit(1'b0, 1'b1, 1'b1);
    check(col_seen - c0, 1, "collision pulse");
    check(int'(active), 0, "backed off");
    check(int'(bus_drive), 1, "recessive after collision");
    wait_grant(n);
    check(n, 9, "priority kept after collision");
    // competitor drives 1 while this station drives 0: no collision
    c0 = col_seen;
    bus_bit(1'b1, 1'b1, 1'b0);
    bus_bit(1'b1, 1'b1, 1'b1);
    check(col_seen - c0, 0, "zero driver keeps line");
    cur_req = "R7";
    send_frame(4);

    // R8: revert to normal priority after a lowered run with no request
    cur_req = "R8";
    for (int i = 0; i < 9; i++) bus_bit(1'b1, 1'b0, 1'b1);
    bus_bit(1'b0, 1'b0, 1'b1);
    wait_grant(n);
    check(n, 8, "normal run after revert");
    send_frame(3);

    // R2: class 1 lowered needs 11, class 3 normal needs 10
    cur_req = "R2";
    prio_class = 2'd1;
    bus_bit(1'b0, 1'b1, 1'b1);
    wait_grant(n);
    check(n, 11, "class1 lowered run");
    send_frame(5);
    for (int i = 0; i < 11; i++) bus_bit(1'b1, 1'b0, 1'b1);
    prio_class = 2'd3;
    bus_bit(1'b0, 1'b1, 1'b1);
    wait_grant(n);
    check(n, 10, "class3 normal run");
    send_frame(2);

    // R2: saturated count grants on the first one
    prio_class = 2'd0;
    for (int i = 0; i < 15; i++) bus_bit(1'b1, 1'b0, 1'b1);
    wait_grant(n);
    check(n, 1, "saturated count grants at once");
    send_frame(1);

    // R9: no change without bit_en
    cur_req = "R9";
    bus_bit(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      echo_in = 1'b1; frame_req = 1'b1; tx_bit = i[0];
    end
    check(int'(active), 0, "no grant without enable");
    wait_grant(n);
    check(n, 9, "count untouched without enable");

    // R6: collision on the final bit wins over frame end
    cur_req = "R6";
    c0 = col_seen; d0 = done_seen;
    bus_bit(1'b1, 1'b1, 1'b1);
    bus_bit(1'b0, 1'b0, 1'b1);
    check(col_seen - c0, 1, "collision on last bit");
    check(done_seen - d0, 0, "no done on collision");

    cur_req = "R10";
    repeat (5) bus_bit(1'b0, 1'b0, 1'b0);
    check(int'(bus_drive), 1, "recessive while idle");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule